// File: doc/BRIEF.md
# Memory Command Sequencer Engine

This block plays a short program of DRAM command words onto one command/address port of a memory controller. A host writes up to `ENTRIES` instructions through a simple word-write port. Each instruction has two words. The pattern word holds the bus value to drive, with the clock-enable bits in its lowest bits. The control word holds the index of the following instruction, an idle gap, a repeat count and a last-instruction flag.

A start pulse runs the program from instruction 0. The engine walks the chain of instructions and issues each command one or more times, with deselect cycles between issues. It stops at the flagged instruction, at an illegal index, or on a stop pulse. A 64-bit status word reports busy, done and three failure flags.

A bus-select input decides who owns the port bus. When it is low, every port carries the mainline controller's value. When it is high, the single port latched at start carries the engine's output.

Top module: `cmdseq_top`

## Requirements
- R1: After reset the status word is zero. With bus select high, port 0 carries the deselect pattern: all bits above the clock-enable field are ones, and the clock-enable field (bits 1:0) is zero.
- R2: A write with address bit 5 clear stores the pattern word of instruction addr[4:0], taken from data bits 31:0. A write with address bit 5 set stores the control word of that instruction and marks it valid. The control word fields are: next index in bits 7:0, idle gap in bits 23:8, repeat count in bits 39:32, last flag in bit 63.
- R3: A start pulse while idle begins at instruction 0. From the next cycle the status word is busy only (bit 63 set, all other bits clear), so done and every failure flag from an earlier run are cleared.
- R4: A non-last instruction with idle gap I and repeat count R is issued R+1 times. Each issue occupies max(I,1) cycles: the first cycle carries the pattern and the remaining cycles carry the deselect pattern.
- R5: When an instruction finishes, execution continues at the instruction given by its next-index field.
- R6: An instruction with the last flag is driven for exactly one cycle, and its idle gap and repeat count are ignored. The engine then goes idle with status equal to done only (bit 62, value 0x4000_0000_0000_0000).
- R7: Reaching an index of `ENTRIES` or more, or an instruction whose control word was never written, drives no pattern. The engine stops with done and failure bit 61 set (0x6000_0000_0000_0000).
- R8: A stop pulse during a run ends it in the same cycle, leaving done and failure bit 60 set (0x5000_0000_0000_0000). A stop pulse while idle changes nothing.
- R9: With bus select low, every port carries its mainline input. With it high, only the port selected at start carries the engine output. The port select is sampled only at start.
- R10: If bus select is low during any running cycle, failure bit 59 is set. It is reported together with done when the run ends.
- R11: Outside pattern cycles, the engine drives the deselect pattern, with the clock-enable bits of the most recently issued pattern held.
- R12: A start pulse during a run is ignored, and the run keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Instruction word write strobe |
| wr_addr_i | input | ADDR_W | Word address: bit 5 selects control word, bits 4:0 the instruction |
| wr_data_i | input | 64 | Word to store |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| port_sel_i | input | PSEL_W | Target port, sampled at start |
| mux_sel_i | input | 1 | Bus ownership: 1 engine, 0 mainline |
| main_bus_i | input | NPORTS*PAT_W | Mainline controller bus per port |
| port_bus_o | output | NPORTS*PAT_W | Bus per port after the ownership mux |
| status_o | output | 64 | Busy 63, done 62, failure flags 61..59 |

## Verification
Every engine output comes straight from registered state, so a start pulse sampled at an edge shows busy and the pattern of instruction 0 in the cycle right after that edge. Done, failure flags and the loss of busy appear in the cycle after the last issue, the bad index or the stop. The bus mux is combinational: a change on bus select is visible in the same cycle. The bench drives inputs and samples outputs on the falling clock edge. It counts busy cycles and pattern issues per run and compares them with max(I,1)·(R+1)+1. Directed checks look at the exact cycle in which each status value or bus value is due.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int WORD_W   = 64;

    // control word layout
    localparam int NEXT_LSB = 0;
    localparam int NEXT_W   = 8;
    localparam int IDLE_LSB = 8;
    localparam int IDLE_W   = 16;
    localparam int REP_LSB  = 32;
    localparam int REP_W    = 8;
    localparam int LAST_BIT = 63;

    // status word layout
    localparam int ST_BUSY   = 63;
    localparam int ST_DONE   = 62;
    localparam int ST_F_IDX  = 61;
    localparam int ST_F_STOP = 60;
    localparam int ST_F_MUX  = 59;

    typedef struct packed {
        logic              last;
        logic [REP_W-1:0]  rep;
        logic [IDLE_W-1:0] idle;
        logic [NEXT_W-1:0] next;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.last = w[LAST_BIT];
        c.rep  = w[REP_LSB  +: REP_W];
        c.idle = w[IDLE_LSB +: IDLE_W];
        c.next = w[NEXT_LSB +: NEXT_W];
        return c;
    endfunction

endpackage

// File: rtl/cmdseq_store.sv
module cmdseq_store
    import cmdseq_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PAT_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic [NEXT_W-1:0]  rd_idx_i,
    output logic [PAT_W-1:0]   rd_pat_o,
    output ctl_t               rd_ctl_o,
    output logic               rd_ok_o
);

    logic [PAT_W-1:0]   pat_mem [ENTRIES];
    ctl_t               ctl_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_d, valid_q;

    logic [IDX_W-1:0] wr_idx, rd_sel;
    logic             wr_in_range, rd_in_range;

    always_comb begin
        wr_idx      = wr_addr_i[IDX_W-1:0];
        wr_in_range = int'(wr_idx) < ENTRIES;
        rd_sel      = rd_idx_i[IDX_W-1:0];
        rd_in_range = int'(rd_idx_i) < ENTRIES;
        valid_d     = valid_q;
        if (wr_en_i && wr_in_range && wr_addr_i[IDX_W])
            valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && wr_in_range) begin
            if (wr_addr_i[IDX_W]) ctl_mem[wr_idx] <= unpack_ctl(wr_data_i);
            else                  pat_mem[wr_idx] <= wr_data_i[PAT_W-1:0];
        end
    end

    always_comb begin
        rd_pat_o = pat_mem[rd_sel];
        rd_ctl_o = ctl_mem[rd_sel];
        rd_ok_o  = rd_in_range && valid_q[rd_sel];
    end

endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
    import cmdseq_pkg::*;
#(
    parameter int PAT_W  = 32,
    parameter int CKE_W  = 2,
    parameter int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              mux_sel_i,
    input  logic [PSEL_W-1:0] port_sel_i,
    output logic [NEXT_W-1:0] rd_idx_o,
    input  logic [PAT_W-1:0]  rd_pat_i,
    input  ctl_t              rd_ctl_i,
    input  logic              rd_ok_i,
    output logic [PAT_W-1:0]  eng_bus_o,
    output logic [PSEL_W-1:0] psel_o,
    output logic [WORD_W-1:0] status_o
);

    typedef struct packed {
        logic              run;
        logic [NEXT_W-1:0] pc;
        logic [REP_W-1:0]  rep;
        logic [IDLE_W-1:0] gap;
        logic [CKE_W-1:0]  cke;
        logic [PSEL_W-1:0] psel;
        logic              done;
        logic              f_idx;
        logic              f_stop;
        logic              f_mux;
    } state_t;

    state_t            s_d, s_q;
    logic [IDLE_W-1:0] slot_len;
    logic              issue_slot, advance;

    always_comb begin
        s_d        = s_q;
        advance    = 1'b0;
        issue_slot = s_q.run && (s_q.gap == '0);
        slot_len   = (rd_ctl_i.idle == '0) ? IDLE_W'(1) : rd_ctl_i.idle;

        if (issue_slot && rd_ok_i)
            s_d.cke = rd_pat_i[CKE_W-1:0];

        if (s_q.run) begin
            if (!mux_sel_i)
                s_d.f_mux = 1'b1;
            if (stop_i) begin
                s_d.run    = 1'b0;
                s_d.done   = 1'b1;
                s_d.f_stop = 1'b1;
            end else if (issue_slot) begin
                if (!rd_ok_i) begin
                    s_d.run   = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.f_idx = 1'b1;
                end else if (rd_ctl_i.last) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end else if (slot_len == IDLE_W'(1)) begin
                    advance = 1'b1;
                end else begin
                    s_d.gap = slot_len - IDLE_W'(1);
                end
            end else begin
                s_d.gap = s_q.gap - IDLE_W'(1);
                if (s_q.gap == IDLE_W'(1))
                    advance = 1'b1;
            end
            if (advance) begin
                if (s_q.rep == rd_ctl_i.rep) begin
                    s_d.pc  = rd_ctl_i.next;
                    s_d.rep = '0;
                end else begin
                    s_d.rep = s_q.rep + REP_W'(1);
                end
            end
        end else if (start_i) begin
            s_d.run    = 1'b1;
            s_d.pc     = '0;
            s_d.rep    = '0;
            s_d.gap    = '0;
            s_d.psel   = port_sel_i;
            s_d.done   = 1'b0;
            s_d.f_idx  = 1'b0;
            s_d.f_stop = 1'b0;
            s_d.f_mux  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_idx_o  = s_q.pc;
        psel_o    = s_q.psel;
        eng_bus_o = (issue_slot && rd_ok_i) ? rd_pat_i
                                            : {{(PAT_W-CKE_W){1'b1}}, s_q.cke};
        status_o            = '0;
        status_o[ST_BUSY]   = s_q.run;
        status_o[ST_DONE]   = s_q.done;
        status_o[ST_F_IDX]  = s_q.f_idx;
        status_o[ST_F_STOP] = s_q.f_stop;
        status_o[ST_F_MUX]  = s_q.f_mux;
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[ST_BUSY] && start_i |=> status_o[ST_BUSY] && !status_o[ST_DONE]); // R3
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[ST_BUSY] |-> !status_o[ST_DONE]); // R3
    AST_END_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        issue_slot && rd_ok_i && rd_ctl_i.last && !stop_i
        |=> status_o[ST_DONE] && !status_o[ST_BUSY] && !status_o[ST_F_IDX]); // R6
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        issue_slot && !rd_ok_i && !stop_i
        |=> status_o[ST_F_IDX] && !status_o[ST_BUSY]); // R7
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && stop_i
        |=> !status_o[ST_BUSY] && status_o[ST_DONE] && status_o[ST_F_STOP]); // R8
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && start_i && !stop_i && (s_q.gap > IDLE_W'(1))
        |=> s_q.run && $stable(rd_idx_o) && $stable(psel_o)); // R12

endmodule

// File: rtl/cmdseq_portmux.sv
module cmdseq_portmux #(
    parameter int NPORTS = 4,
    parameter int PAT_W  = 32,
    parameter int PSEL_W = 2
) (
    input  logic                    mux_sel_i,
    input  logic [PSEL_W-1:0]       psel_i,
    input  logic [PAT_W-1:0]        eng_bus_i,
    input  logic [NPORTS*PAT_W-1:0] main_bus_i,
    output logic [NPORTS*PAT_W-1:0] port_bus_o
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic own;
        assign own = mux_sel_i && (psel_i == PSEL_W'(p));
        assign port_bus_o[p*PAT_W +: PAT_W] = own ? eng_bus_i
                                                  : main_bus_i[p*PAT_W +: PAT_W];
    end

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PAT_W   = 32,
    parameter int CKE_W   = 2,
    parameter int NPORTS  = 4,
    localparam int ADDR_W = $clog2(ENTRIES) + 1,
    localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [63:0]             wr_data_i,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic [PSEL_W-1:0]       port_sel_i,
    input  logic                    mux_sel_i,
    input  logic [NPORTS*PAT_W-1:0] main_bus_i,
    output logic [NPORTS*PAT_W-1:0] port_bus_o,
    output logic [63:0]             status_o
);

    logic [NEXT_W-1:0] rd_idx;
    logic [PAT_W-1:0]  rd_pat, eng_bus;
    ctl_t              rd_ctl;
    logic              rd_ok;
    logic [PSEL_W-1:0] psel;

    cmdseq_store #(.ENTRIES(ENTRIES), .PAT_W(PAT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_idx_i  (rd_idx),
        .rd_pat_o  (rd_pat),
        .rd_ctl_o  (rd_ctl),
        .rd_ok_o   (rd_ok)
    );

    cmdseq_engine #(.PAT_W(PAT_W), .CKE_W(CKE_W), .PSEL_W(PSEL_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .mux_sel_i  (mux_sel_i),
        .port_sel_i (port_sel_i),
        .rd_idx_o   (rd_idx),
        .rd_pat_i   (rd_pat),
        .rd_ctl_i   (rd_ctl),
        .rd_ok_i    (rd_ok),
        .eng_bus_o  (eng_bus),
        .psel_o     (psel),
        .status_o   (status_o)
    );

    cmdseq_portmux #(.NPORTS(NPORTS), .PAT_W(PAT_W), .PSEL_W(PSEL_W)) u_mux (
        .mux_sel_i  (mux_sel_i),
        .psel_i     (psel),
        .eng_bus_i  (eng_bus),
        .main_bus_i (main_bus_i),
        .port_bus_o (port_bus_o)
    );

endmodule

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;

    localparam logic [31:0] PA = 32'h1234_5673;   // cke 11
    localparam logic [31:0] PB = 32'h0000_00A1;   // cke 01
    localparam logic [31:0] PC = 32'h0000_0C02;   // cke 10
    localparam logic [63:0] ST_OK    = 64'h4000_0000_0000_0000;
    localparam logic [63:0] ST_BUSY  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ST_FIDX  = 64'h6000_0000_0000_0000;
    localparam logic [63:0] ST_FSTOP = 64'h5000_0000_0000_0000;
    localparam logic [63:0] ST_FMUX  = 64'h4800_0000_0000_0000;
    localparam logic [127:0] MAIN = {32'hDDDD_0003, 32'hCCCC_0002,
                                     32'hBBBB_0001, 32'hAAAA_0000};

    // idle, repeat, expected busy cycles, expected issues
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{1, 0, 2, 1}, '{0, 0, 2, 1}, '{3, 1, 7, 2},
        '{2, 3, 9, 4}, '{5, 0, 6, 1}, '{0, 4, 6, 5}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [63:0]  wr_data = '0;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic [1:0]   port_sel = '0;
    logic         mux_sel = 1'b0;
    logic [127:0] port_bus;
    logic [63:0]  status;

    int n_cmp = 0;
    int n_mis = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmdseq_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .start_i    (start),
        .stop_i     (stop),
        .port_sel_i (port_sel),
        .mux_sel_i  (mux_sel),
        .main_bus_i (MAIN),
        .port_bus_o (port_bus),
        .status_o   (status)
    );

    function automatic logic [63:0] ctlw(input bit last, input int rep,
                                         input int idle, input int nxt);
        logic [63:0] w;
        w = '0;
        w[7:0]   = 8'(nxt);
        w[23:8]  = 16'(idle);
        w[39:32] = 8'(rep);
        w[63]    = last;
        return w;
    endfunction

    function automatic logic [31:0] pbus(input int p);
        return port_bus[p*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic run_count(output int cyc, output int iss);
        cyc = 0; iss = 0;
        while (status[63] && cyc < 2000) begin
            if (pbus(0) == PA) iss++;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        int guard = 0;
        while (status[63] && guard < 2000) begin guard++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        int cyc, iss;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state; R9 mainline ownership
        chk("R1 status after reset", status, 64'h0);
        chk("R9 mux low passes mainline", port_bus, MAIN);
        mux_sel = 1'b1; #1;
        chk("R1 deselect with cke 0", {32'h0, pbus(0)}, 64'hFFFF_FFFC);
        chk("R9 unselected port mainline", {32'h0, pbus(1)}, {32'h0, MAIN[63:32]});

        // R4 table of repeat/idle shapes, R6 success status
        for (int r = 0; r < NVEC; r++) begin
            wr(0, {32'h0, PA});
            wr(32, ctlw(1'b0, VEC[r][1], VEC[r][0], 1));
            wr(1, {32'h0, PB});
            wr(33, ctlw(1'b1, 7, 9, 0));
            kick();
            run_count(cyc, iss);
            chk("R4 busy cycles", 64'(cyc), 64'(VEC[r][2]));
            chk("R4 issue count", 64'(iss), 64'(VEC[r][3]));
            chk("R6 done only", status, ST_OK);
        end

        // R2, R5 jump to entry 5
        wr(32, ctlw(1'b0, 0, 1, 5));
        wr(5, {32'h0, PC});
        wr(37, ctlw(1'b1, 0, 0, 0));
        kick();
        chk("R2 entry 0 pattern", {32'h0, pbus(0)}, {32'h0, PA});
        @(negedge clk);
        chk("R5 jump target pattern", {32'h0, pbus(0)}, {32'h0, PC});
        @(negedge clk);
        chk("R6 one cycle last entry", status, ST_OK);
        chk("R11 held cke deselect", {32'h0, pbus(0)}, 64'hFFFF_FFFE);

        // R7 index out of range
        wr(32, ctlw(1'b0, 0, 1, 40));
        kick();
        chk("R7 first entry issued", {32'h0, pbus(0)}, {32'h0, PA});
        @(negedge clk);
        chk("R7 no pattern at bad index", {32'h0, pbus(0)}, 64'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 out of range fail", status, ST_FIDX);

        // R7 unwritten entry
        wr(32, ctlw(1'b0, 0, 1, 9));
        kick();
        @(negedge clk); @(negedge clk);
        chk("R7 unwritten entry fail", status, ST_FIDX);

        // R3 start clears flags
        wr(32, ctlw(1'b0, 0, 1, 1));
        kick();
        chk("R3 busy only after start", status, ST_BUSY);
        finish_run();
        chk("R3 clean done", status, ST_OK);

        // R8 stop during run, stop while idle
        wr(32, ctlw(1'b0, 0, 100, 1));
        kick();
        repeat (3) @(negedge clk);
        chk("R8 still running", status, ST_BUSY);
        pulse_stop();
        chk("R8 stop status", status, ST_FSTOP);
        pulse_stop();
        chk("R8 idle stop no effect", status, ST_FSTOP);

        // R12 restart ignored
        wr(32, ctlw(1'b0, 0, 10, 1));
        kick();
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (status[63] && cyc < 2000) begin cyc++; @(negedge clk); end
        chk("R12 run timing kept", 64'(cyc), 64'd6);

        // R9 port select, R10 bus loss
        wr(32, ctlw(1'b0, 0, 3, 1));
        port_sel = 2'd2;
        kick();
        chk("R9 selected port driven", {32'h0, pbus(2)}, {32'h0, PA});
        chk("R9 other port mainline", {32'h0, pbus(0)}, {32'h0, MAIN[31:0]});
        port_sel = 2'd1;
        mux_sel = 1'b0;
        @(negedge clk);
        chk("R9 mux low mainline", {32'h0, pbus(2)}, {32'h0, MAIN[95:64]});
        mux_sel = 1'b1;
        finish_run();
        chk("R10 bus loss flag", status, ST_FMUX);
        chk("R11 idle deselect held cke", {32'h0, pbus(2)}, 64'hFFFF_FFFD);
        chk("R9 select latched at start", {32'h0, pbus(1)}, {32'h0, MAIN[63:32]});

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule